// File: doc/BRIEF.md
# Speaker Path Automatic Gain Limiter

This block watches the signed sample stream heading to a loudspeaker and works out how many decibels of gain to take away so that the speaker neither clips nor is driven beyond a power budget. Two detectors run side by side: a peak detector that compares each sample magnitude against a clip threshold, and a power detector that keeps a leaky running average of squared samples and compares it against a power threshold. Each detector has its own enable, its own 4-bit threshold and its own pair of 3-bit rate codes, one for attack and one for release.

Each detector drives its own attenuation counter in 1 dB steps. The counter climbs at the attack rate while its detector reports an overload and falls back at the release rate once the overload is gone. The block reports the larger of the two attenuations and also applies it to the user volume code. The result is clamped at a programmable minimum gain code, so the limiter never pushes the path below that floor. A master enable gates both detectors. Everything advances only on sample ticks.

Top module: `spk_gain_limiter`

## Requirements
- R1: After reset `atten_req` is 0 and `gain_code` equals `vol_code`.
- R2: A sample counts as a clip overload when its magnitude is at least (clip_thr+1)·2^(SAMPLE_W-5). This test applies only when both `agc_on` and `clip_on` are 1 and `smp_valid` is 1.
- R3: While a detector sees overload on consecutive valid ticks, its attenuation rises by 1 dB on every 2^atk-th such tick. With a code of 0, the first overload tick already steps.
- R4: While a detector sees no overload on consecutive valid ticks, its attenuation falls by 1 dB on every 2^(dcy+4)-th such tick and never goes below 0.
- R5: On each valid tick the power average moves as avg += (q − avg)>>k, with truncation toward the old value. Here q = (sample²)>>SAMPLE_W, and k is 6 when `pwr_slow` is 1 and 3 otherwise. The power detector reports overload on a valid tick when the average held before that tick is at least (pwr_thr+1)·2^(SAMPLE_W-6).
- R6: `atten_req` is the larger of the clip attenuation and the power attenuation.
- R7: `gain_code` is `vol_code` when `vol_code` ≤ `min_gain`. Otherwise it is max(`vol_code` − `atten_req`, `min_gain`).
- R8: When `agc_on` is 0, or a detector's own enable is 0, that detector's attenuation and tick count are cleared on the next clock. Samples then have no effect on it.
- R9: Each detector's attenuation saturates at 63 under continued overload.
- R10: Cycles with `smp_valid` low leave both attenuations unchanged.
- R11: Any change between overload and no overload restarts the tick count, so a partial run toward a step is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample tick; `smp_data` is valid |
| smp_data | input | SAMPLE_W | Signed output sample |
| agc_on | input | 1 | Master enable for both detectors |
| clip_on | input | 1 | Clip detector enable |
| clip_thr | input | 4 | Clip threshold code |
| clip_atk | input | 3 | Clip attack rate code |
| clip_dcy | input | 3 | Clip release rate code |
| pwr_on | input | 1 | Power detector enable |
| pwr_thr | input | 4 | Power threshold code |
| pwr_atk | input | 3 | Power attack rate code |
| pwr_dcy | input | 3 | Power release rate code |
| pwr_slow | input | 1 | Selects the long averaging time constant |
| min_gain | input | 6 | Gain code floor |
| vol_code | input | 6 | User volume code |
| atten_req | output | 6 | Requested attenuation in dB |
| gain_code | output | 6 | Volume code after limiting |

## Verification
The bench drives a magnitude that sits exactly on the clip level, and the most negative sample. A detector that used a strict compare, or that lost the sign when taking the magnitude, would miss these overloads and leave the attenuation short. Overload runs are broken by one quiet tick to show that a partial run is thrown away; a design that kept counting would step one tick early. The bench also runs long overloads to hit saturation at 63, where a design without saturation would wrap to 0. Volume settings at, below and above the floor check the clamp: a wrong clamp would either drop the gain under `min_gain` or raise a volume that already sits under it. Random runs with both detectors active check that the larger attenuation wins and that the leaky power average steps exactly as stated.

// File: rtl/spk_agc_pkg.sv
package spk_agc_pkg;
  parameter int unsigned GAIN_W      = 6;
  parameter int unsigned THR_W       = 4;
  parameter int unsigned RATE_W      = 3;
  parameter int unsigned DECAY_EXTRA = 4;
  localparam int unsigned MAX_SHIFT  = (1 << RATE_W) - 1 + DECAY_EXTRA;
  localparam int unsigned CNT_W      = MAX_SHIFT + 1;

  typedef logic [GAIN_W-1:0] gain_t;
  typedef logic [CNT_W-1:0]  tick_t;

  // ticks per 1 dB step for a rate code
  function automatic tick_t step_len(input logic [RATE_W-1:0] code, input logic release_mode);
    int unsigned sh;
    sh = 32'(code) + (release_mode ? DECAY_EXTRA : 0);
    return tick_t'(1) << sh;
  endfunction

  function automatic gain_t larger(input gain_t a, input gain_t b);
    return (a > b) ? a : b;
  endfunction

  // apply attenuation to volume without dropping below the floor
  function automatic gain_t floor_gain(input gain_t vol, input gain_t floor_code, input gain_t att);
    logic signed [GAIN_W+1:0] diff;
    diff = $signed({2'b00, vol}) - $signed({2'b00, att});
    if (vol <= floor_code) return vol;
    if (diff < $signed({2'b00, floor_code})) return floor_code;
    return diff[GAIN_W-1:0];
  endfunction
endpackage

// File: rtl/agc_power_avg.sv
module agc_power_avg
  import spk_agc_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned SHORT_SH = 3,
  parameter int unsigned LONG_SH  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                slow,
  output logic [SAMPLE_W-1:0] avg
);
  localparam int unsigned SQ_W = 2 * SAMPLE_W;

  logic signed [SQ_W-1:0]     sq_full;
  logic        [SAMPLE_W-1:0] sq_hi;
  logic        [SAMPLE_W-1:0] avg_q, avg_nx, gap;
  int unsigned                sh;

  always_comb begin
    sq_full = $signed(sample) * $signed(sample);
    sq_hi   = sq_full[SQ_W-1:SAMPLE_W];
    sh      = slow ? LONG_SH : SHORT_SH;
    if (sq_hi >= avg_q) begin
      gap    = sq_hi - avg_q;
      avg_nx = avg_q + (gap >> sh);
    end else begin
      gap    = avg_q - sq_hi;
      avg_nx = avg_q - (gap >> sh);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    avg_q <= '0;
    else if (tick) avg_q <= avg_nx;
  end

  assign avg = avg_q;

  // R5: average can never pass the largest possible squared term
  a_r5_avg_bound: assert property (@(posedge clk) disable iff (!rst_n)
    avg_q <= (SAMPLE_W)'(1) << (SAMPLE_W - 2));
  // R10: no tick, no movement
  a_r10_avg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(avg_q));
endmodule

// File: rtl/agc_rate_stepper.sv
module agc_rate_stepper
  import spk_agc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              tick,
  input  logic              over,
  input  logic [RATE_W-1:0] atk_code,
  input  logic [RATE_W-1:0] dcy_code,
  output gain_t             atten
);
  localparam gain_t ATT_MAX = '1;

  gain_t atten_q;
  tick_t cnt_q, run_len, target;
  logic  last_q;
  logic  step_due, step_up, step_dn;

  always_comb begin
    run_len  = (over == last_q) ? cnt_q + tick_t'(1) : tick_t'(1);
    target   = over ? step_len(atk_code, 1'b0) : step_len(dcy_code, 1'b1);
    step_due = active && tick && (run_len == target);
    step_up  = step_due && over  && (atten_q != ATT_MAX);
    step_dn  = step_due && !over && (atten_q != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      atten_q <= '0;
      cnt_q   <= '0;
      last_q  <= 1'b0;
    end else if (tick) begin
      last_q <= over;
      cnt_q  <= step_due ? '0 : run_len;
      if (step_up)      atten_q <= atten_q + gain_t'(1);
      else if (step_dn) atten_q <= atten_q - gain_t'(1);
    end
  end

  assign atten = atten_q;

  // R3, R4: at most one dB per clock in either direction
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (({1'b0, atten_q} == {1'b0, $past(atten_q)}) ||
                ({1'b0, atten_q} == {1'b0, $past(atten_q)} + (GAIN_W+1)'(1)) ||
                ({1'b0, atten_q} + (GAIN_W+1)'(1) == {1'b0, $past(atten_q)})));
  // R8: a disabled detector holds no attenuation
  a_r8_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (atten_q == '0));
  // R10: idle cycles leave attenuation alone
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> $stable(atten_q));
  // R9: saturated attenuation stays put under overload
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick && over && atten_q == ATT_MAX) |=> (atten_q == ATT_MAX));
endmodule

// File: rtl/agc_gain_merge.sv
module agc_gain_merge
  import spk_agc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  gain_t att_clip,
  input  gain_t att_pwr,
  input  gain_t vol,
  input  gain_t floor_code,
  output gain_t att_out,
  output gain_t gain_out
);
  always_comb begin
    att_out  = larger(att_clip, att_pwr);
    gain_out = floor_gain(vol, floor_code, att_out);
  end

  // R7: never below the floor when volume sits above it
  a_r7_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (vol > floor_code) |-> (gain_out >= floor_code));
  // R7: limiting never raises gain
  a_r7_no_boost: assert property (@(posedge clk) disable iff (!rst_n)
    gain_out <= vol);
  // R6: reported attenuation covers both detectors
  a_r6_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (att_out >= att_clip) && (att_out >= att_pwr));
endmodule

// File: rtl/spk_gain_limiter.sv
module spk_gain_limiter
  import spk_agc_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned SHORT_SH = 3,
  parameter int unsigned LONG_SH  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                agc_on,
  input  logic                clip_on,
  input  logic [THR_W-1:0]    clip_thr,
  input  logic [RATE_W-1:0]   clip_atk,
  input  logic [RATE_W-1:0]   clip_dcy,
  input  logic                pwr_on,
  input  logic [THR_W-1:0]    pwr_thr,
  input  logic [RATE_W-1:0]   pwr_atk,
  input  logic [RATE_W-1:0]   pwr_dcy,
  input  logic                pwr_slow,
  input  logic [GAIN_W-1:0]   min_gain,
  input  logic [GAIN_W-1:0]   vol_code,
  output logic [GAIN_W-1:0]   atten_req,
  output logic [GAIN_W-1:0]   gain_code
);
  localparam int unsigned N_LIM     = 2;
  localparam int unsigned LIM_CLIP  = 0;
  localparam int unsigned LIM_PWR   = 1;
  localparam int unsigned MAG_W     = SAMPLE_W + 1;
  localparam int unsigned CLIP_SH   = SAMPLE_W - THR_W - 1;
  localparam int unsigned PWR_SH    = SAMPLE_W - THR_W - 2;

  logic signed [MAG_W-1:0]    sx;
  logic        [MAG_W-1:0]    mag, clip_level;
  logic        [SAMPLE_W-1:0] pwr_avg, pwr_level;
  logic                       clip_over, pwr_over;

  logic                       lim_active [N_LIM];
  logic                       lim_over   [N_LIM];
  logic        [RATE_W-1:0]   lim_atk    [N_LIM];
  logic        [RATE_W-1:0]   lim_dcy    [N_LIM];
  gain_t                      lim_att    [N_LIM];

  // peak magnitude against clip level
  always_comb begin
    sx         = $signed({smp_data[SAMPLE_W-1], smp_data});
    mag        = (sx < 0) ? MAG_W'(-sx) : MAG_W'(sx);
    clip_level = (MAG_W'(clip_thr) + MAG_W'(1)) << CLIP_SH;
    clip_over  = mag >= clip_level;
    pwr_level  = (SAMPLE_W'(pwr_thr) + SAMPLE_W'(1)) << PWR_SH;
    pwr_over   = pwr_avg >= pwr_level;
  end

  agc_power_avg #(
    .SAMPLE_W(SAMPLE_W), .SHORT_SH(SHORT_SH), .LONG_SH(LONG_SH)
  ) i_pwr (
    .clk(clk), .rst_n(rst_n), .tick(smp_valid), .sample(smp_data),
    .slow(pwr_slow), .avg(pwr_avg)
  );

  always_comb begin
    lim_active[LIM_CLIP] = agc_on && clip_on;
    lim_over[LIM_CLIP]   = clip_over;
    lim_atk[LIM_CLIP]    = clip_atk;
    lim_dcy[LIM_CLIP]    = clip_dcy;
    lim_active[LIM_PWR]  = agc_on && pwr_on;
    lim_over[LIM_PWR]    = pwr_over;
    lim_atk[LIM_PWR]     = pwr_atk;
    lim_dcy[LIM_PWR]     = pwr_dcy;
  end

  for (genvar g = 0; g < N_LIM; g++) begin : g_lim
    agc_rate_stepper i_step (
      .clk(clk), .rst_n(rst_n), .active(lim_active[g]), .tick(smp_valid),
      .over(lim_over[g]), .atk_code(lim_atk[g]), .dcy_code(lim_dcy[g]),
      .atten(lim_att[g])
    );
  end

  agc_gain_merge i_merge (
    .clk(clk), .rst_n(rst_n), .att_clip(lim_att[LIM_CLIP]), .att_pwr(lim_att[LIM_PWR]),
    .vol(vol_code), .floor_code(min_gain), .att_out(atten_req), .gain_out(gain_code)
  );

  // R1: nothing is taken away in the cycle after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (atten_req == '0));
endmodule

// File: tb/test_spk_gain_limiter.sv
module test_spk_gain_limiter;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [SW-1:0] smp_data = '0;
  logic agc_on = 1'b0, clip_on = 1'b0, pwr_on = 1'b0, pwr_slow = 1'b0;
  logic [3:0] clip_thr = '0, pwr_thr = '0;
  logic [2:0] clip_atk = '0, clip_dcy = '0, pwr_atk = '0, pwr_dcy = '0;
  logic [5:0] min_gain = '0, vol_code = 6'd45;
  logic [5:0] atten_req, gain_code;

  int n_checks = 0;
  int n_fails = 0;

  // reference state
  int m_att[2], m_cnt[2], m_last[2];
  int m_avg;

  always #2.5 clk = ~clk;

  spk_gain_limiter i_spk_gain_limiter (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .agc_on(agc_on), .clip_on(clip_on), .clip_thr(clip_thr), .clip_atk(clip_atk),
    .clip_dcy(clip_dcy), .pwr_on(pwr_on), .pwr_thr(pwr_thr), .pwr_atk(pwr_atk),
    .pwr_dcy(pwr_dcy), .pwr_slow(pwr_slow), .min_gain(min_gain), .vol_code(vol_code),
    .atten_req(atten_req), .gain_code(gain_code)
  );

  function automatic int b_ticks(input int code, input bit rel);
    return rel ? (16 << code) : (1 << code);
  endfunction

  function automatic int b_gain(input int vol, input int mn, input int att);
    if (vol <= mn) return vol;
    if (vol - att < mn) return mn;
    return vol - att;
  endfunction

  function automatic int b_mag(input logic [SW-1:0] s);
    int v;
    v = int'($signed(s));
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 2; i++) begin
      m_att[i] = 0; m_cnt[i] = 0; m_last[i] = 0;
    end
    m_avg = 0;
  endtask

  // next state after the coming edge, from the inputs now applied
  task automatic model_next();
    bit act [2];
    bit ov [2];
    int atk [2], dcy [2];
    int q, sv, gap, run, tgt;
    act[0] = agc_on && clip_on;
    act[1] = agc_on && pwr_on;
    ov[0]  = b_mag(smp_data) >= ((int'(clip_thr) + 1) << 11);
    ov[1]  = m_avg >= ((int'(pwr_thr) + 1) << 10);
    atk[0] = clip_atk; dcy[0] = clip_dcy;
    atk[1] = pwr_atk;  dcy[1] = pwr_dcy;
    for (int i = 0; i < 2; i++) begin
      if (!act[i]) begin
        m_att[i] = 0; m_cnt[i] = 0; m_last[i] = 0;
      end else if (smp_valid) begin
        run = (int'(ov[i]) == m_last[i]) ? m_cnt[i] + 1 : 1;
        tgt = ov[i] ? b_ticks(atk[i], 0) : b_ticks(dcy[i], 1);
        if (run == tgt) begin
          m_cnt[i] = 0;
          if (ov[i] && m_att[i] < 63) m_att[i]++;
          else if (!ov[i] && m_att[i] > 0) m_att[i]--;
        end else m_cnt[i] = run;
        m_last[i] = ov[i];
      end
    end
    if (smp_valid) begin
      sv = int'($signed(smp_data));
      q  = (sv * sv) >>> SW;
      if (q >= m_avg) begin
        gap = q - m_avg; m_avg = m_avg + (gap >> (pwr_slow ? 6 : 3));
      end else begin
        gap = m_avg - q; m_avg = m_avg - (gap >> (pwr_slow ? 6 : 3));
      end
    end
  endtask

  task automatic compare(input string req);
    int ea;
    ea = (m_att[0] > m_att[1]) ? m_att[0] : m_att[1];
    chk(req, "atten_req", int'(atten_req), ea);
    chk(req, "gain_code", int'(gain_code), b_gain(int'(vol_code), int'(min_gain), ea));
  endtask

  task automatic step(input logic v, input logic [SW-1:0] s, input string req);
    smp_valid = v;
    smp_data  = s;
    model_next();
    @(negedge clk);
    compare(req);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model_next();
    // R1 reset state
    chk("R1", "atten_req", int'(atten_req), 0);
    chk("R1", "gain_code", int'(gain_code), 45);

    // R2, R3: clip attack at one tick per dB
    agc_on = 1; clip_on = 1; clip_thr = 4'd7; clip_atk = 3'd0; clip_dcy = 3'd0;
    repeat (5) step(1'b1, 16'sd20000, "R3");
    chk("R3", "five attack steps", int'(atten_req), 5);
    step(1'b1, 16'h C000, "R2");        // magnitude exactly on the level
    chk("R2", "boundary magnitude", int'(atten_req), 6);
    step(1'b1, 16'sd16383, "R2");       // one below the level
    chk("R2", "below level", int'(atten_req), 6);
    // R10: loud data without tick
    repeat (10) step(1'b0, 16'sd30000, "R10");
    chk("R10", "held without tick", int'(atten_req), 6);
    // R4: release every 16 ticks
    repeat (31) step(1'b1, 16'sd100, "R4");
    chk("R4", "two release steps", int'(atten_req), 4);

    // R11: broken run is discarded
    clip_atk = 3'd2;
    repeat (3) step(1'b1, 16'sd20000, "R11");
    step(1'b1, 16'sd0, "R11");
    repeat (3) step(1'b1, 16'sd20000, "R11");
    chk("R11", "no step after broken run", int'(atten_req), 4);
    step(1'b1, 16'h8000, "R11");        // most negative sample is loud
    chk("R11", "step after full run", int'(atten_req), 5);

    // R9: saturation
    clip_atk = 3'd0;
    repeat (70) step(1'b1, 16'sd32767, "R9");
    chk("R9", "saturated", int'(atten_req), 63);

    // R7: floor handling
    vol_code = 6'd45; min_gain = 6'd30; step(1'b0, 16'sd0, "R7");
    chk("R7", "clamped to floor", int'(gain_code), 30);
    vol_code = 6'd20; step(1'b0, 16'sd0, "R7");
    chk("R7", "volume under floor", int'(gain_code), 20);
    vol_code = 6'd63; min_gain = 6'd0; step(1'b0, 16'sd0, "R7");
    chk("R7", "full range", int'(gain_code), 0);

    // R8: disabled detector ignores loud input
    clip_on = 0;
    step(1'b1, 16'sd32767, "R8");
    chk("R8", "cleared", int'(atten_req), 0);
    repeat (8) step(1'b1, 16'sd32767, "R8");
    chk("R8", "ignored", int'(gain_code), 63);
    clip_on = 1; agc_on = 0;
    repeat (4) step(1'b1, 16'sd32767, "R8");
    chk("R8", "master off", int'(atten_req), 0);
    agc_on = 1;

    // R5: power detector on a steady tone
    clip_on = 0; pwr_on = 1; pwr_thr = 4'd2; pwr_atk = 3'd0; pwr_dcy = 3'd0; pwr_slow = 0;
    repeat (40) step(1'b1, 16'sd16384, "R5");
    n_checks++;
    if (atten_req == 0) begin
      n_fails++;
      $display("FAIL R5 power attack: actual %0d expected nonzero", atten_req);
    end
    pwr_slow = 1;
    repeat (200) step(1'b1, 16'sd2000, "R5");

    // R6: both detectors, random stimulus
    for (int c = 0; c < 30000; c++) begin
      if (c % 500 == 0) begin
        agc_on   = ($urandom % 8) != 0;
        clip_on  = $urandom % 2;
        pwr_on   = $urandom % 2;
        clip_thr = $urandom; pwr_thr = $urandom;
        clip_atk = $urandom; pwr_atk = $urandom;
        clip_dcy = $urandom % 4; pwr_dcy = $urandom % 4;
        pwr_slow = $urandom % 2;
        vol_code = $urandom; min_gain = $urandom;
      end
      case ($urandom % 4)
        0: smp_data = $urandom;
        1: smp_data = SW'($signed(int'($urandom % 2048) - 1024));
        2: smp_data = SW'((int'(clip_thr) + 1) << 11) - SW'($urandom % 2);
        default: smp_data = '0;
      endcase
      step(($urandom % 4) != 0, smp_data, "R6");
    end
    finish_run();
  end
endmodule